// File: doc/BRIEF.md
# Memory-Mapped Receive Packet FIFO

This block sits at the end of a 32-bit AXI-Stream link and holds the incoming packets, each ending on the beat with tlast set, until a processor collects them through a simple 32-bit register port. It works in store-and-forward fashion. Words of a packet that is still arriving are held in storage but are not visible to software. When the last beat is stored, the packet's word count goes into a small length queue, and the data of that packet becomes visible.

Software polls the occupancy register or the status register. It then reads the length register, which opens the oldest complete packet and reports its size in bytes. After that it reads the data register once per word. Reads that run past the end of a packet are flagged. So are reads of the data register when nothing is stored, and a fresh length read that leaves words of the previous packet unread. A keyed write to the reset register empties the block. Packets must not be longer than the data storage depth.

Register map, by byte address on `reg_addr`: 0x00 status (write 1 to clear), 0x18 reset key, 0x1C occupancy, 0x20 data, 0x24 length. Any other address reads 0.

Top module: `rx_pkt_fifo`

## Requirements
- R1: After reset, occupancy, length and status all read 0, and `s_tready` is 1.
- R2: Occupancy (0x1C) counts only the stored words of complete packets. It stays 0 while a packet is arriving, and rises by the packet's word count when the tlast beat is stored.
- R3: Each read of length (0x24) returns 4 times the word count of the oldest packet not yet opened, and opens that packet. Packets are opened in arrival order, and the read returns 0 when no complete packet is waiting.
- R4: Each read of data (0x20) within the open packet returns the next word in arrival order, and occupancy drops by 1.
- R5: Storing a beat with tlast sets status bit 26 (packet received).
- R6: A data read while occupancy is 0 returns 0 and sets status bit 29 (underrun).
- R7: A data read while occupancy is nonzero but the open packet has no words left returns 0, removes no word and sets status bit 30 (over-read).
- R8: A length read while the open packet still has unread words sets status bit 31 (under-read). It discards those words, so occupancy drops by their number, and it then opens the next packet.
- R9: Writing exactly 0x000000A5 to 0x18 empties the data storage and the length queue, drops any partial packet and sets status bit 23 (reset done). Any other value written there has no effect.
- R10: Writing to status (0x00) clears each bit written as 1 and leaves the bits written as 0 unchanged. A bit set in the same cycle stays set.
- R11: `s_tready` is 0 while the data storage is full or the length queue is full, so no beat is lost.
- R12: A tlast beat that meets full storage stalls the stream. Its packet is not counted in occupancy until that beat is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 32 | Stream data word |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Beat ends the packet |
| s_tready | output | 1 | Block can accept a beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the strobe |

## Verification
A register read takes effect at the clock edge that samples the strobe. Its value appears on `reg_rdata` from that same edge, which is one cycle after the strobe is raised. A beat is stored, and if it carries tlast it is committed, at the edge where `s_tvalid` and `s_tready` are both high. Occupancy and the status bits therefore show the change on the next access. The bench drives every input on the falling edge and reads `reg_rdata` on the next falling edge, so each value is sampled half a cycle after the edge that produced it. For back-pressure, it reads `s_tready` on a falling edge, after the inputs have settled.

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
  parameter int AW = 8,
  parameter int LW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int DEPTH  = 1 << AW;
  localparam int LDEPTH = 1 << LW;
  localparam int CW     = AW + 1;
  localparam logic [5:0] A_STAT = 6'h00, A_RST = 6'h18, A_OCC = 6'h1C,
                         A_DATA = 6'h20, A_LEN = 6'h24;

  logic [31:0]   mem  [DEPTH];
  logic [CW-1:0] lenq [LDEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lq_wp, lq_rp;
  logic [LW:0]   lq_cnt;
  logic [CW-1:0] fill, occ, cur_left, pkt_words, pkt_len, drop;
  logic [31:0]   status, set_bits, clr_bits;
  logic kick, acc, commit, rd_data, rd_len, under_run, over_rd, pop, skip, lq_empty, lq_pop;

  assign kick      = reg_wr && reg_addr == A_RST && reg_wdata == 32'h0000_00A5;
  assign s_tready  = (fill != CW'(DEPTH)) && (lq_cnt != (LW+1)'(LDEPTH));
  assign acc       = s_tvalid && s_tready;
  assign commit    = acc && s_tlast;
  assign pkt_len   = pkt_words + CW'(1);
  assign rd_data   = reg_rd && reg_addr == A_DATA;
  assign rd_len    = reg_rd && reg_addr == A_LEN;
  assign lq_empty  = lq_cnt == '0;
  assign under_run = rd_data && occ == '0;
  assign over_rd   = rd_data && occ != '0 && cur_left == '0;
  assign pop       = rd_data && cur_left != '0;
  assign skip      = rd_len && cur_left != '0;
  assign lq_pop    = rd_len && !lq_empty;
  assign drop      = pop ? CW'(1) : (skip ? cur_left : '0);

  always_comb begin
    set_bits     = '0;
    set_bits[23] = kick;
    set_bits[26] = commit && !kick;
    set_bits[29] = under_run;
    set_bits[30] = over_rd;
    set_bits[31] = skip;
    clr_bits     = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (acc && !kick) mem[wp] <= s_tdata;
    if (commit && !kick) lenq[lq_wp] <= pkt_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0; occ <= '0; cur_left <= '0; pkt_words <= '0;
      lq_wp <= '0; lq_rp <= '0; lq_cnt <= '0;
    end else if (kick) begin
      wp <= '0; rp <= '0; fill <= '0; occ <= '0; cur_left <= '0; pkt_words <= '0;
      lq_wp <= '0; lq_rp <= '0; lq_cnt <= '0;
    end else begin
      if (acc) begin
        wp        <= wp + AW'(1);
        pkt_words <= s_tlast ? '0 : pkt_words + CW'(1);
      end
      if (commit) lq_wp <= lq_wp + LW'(1);
      if (lq_pop) lq_rp <= lq_rp + LW'(1);
      rp     <= rp + drop[AW-1:0];
      fill   <= fill + CW'(acc) - drop;
      occ    <= occ + (commit ? pkt_len : '0) - drop;
      lq_cnt <= lq_cnt + (LW+1)'(commit) - (LW+1)'(lq_pop);
      if (rd_len)   cur_left <= lq_empty ? '0 : lenq[lq_rp];
      else if (pop) cur_left <= cur_left - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_STAT:  reg_rdata <= status;
        A_OCC:   reg_rdata <= 32'(occ);
        A_DATA:  reg_rdata <= pop ? mem[rp] : '0;
        A_LEN:   reg_rdata <= lq_empty ? '0 : (32'(lenq[lq_rp]) << 2);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tvalid,
  input logic          s_tready,
  input logic          s_tlast,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [5:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   status,
  input logic [AW:0]   fill,
  input logic [AW:0]   occ,
  input logic [AW:0]   cur_left,
  input logic [AW-1:0] rp
);
  localparam int DEPTH = 1 << AW;
  logic kick, rd_data, rd_len;
  assign kick    = reg_wr && reg_addr == 6'h18 && reg_wdata == 32'h0000_00A5;
  assign rd_data = reg_rd && reg_addr == 6'h20;
  assign rd_len  = reg_rd && reg_addr == 6'h24;

  p_full_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill == (AW+1)'(DEPTH) |-> !s_tready);
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= fill);
  p_complete_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && s_tready && s_tlast && !kick |=> status[26]);
  p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && occ == '0 |=> status[29]);
  p_overread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && occ != '0 && cur_left == '0 && !kick |=> status[30] && $stable(rp));
  p_underread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_len && cur_left != '0 && !kick |=> status[31]);
  p_key_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> occ == '0 && fill == '0 && status[23]);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status(status), .fill(fill), .occ(occ), .cur_left(cur_left), .rp(rp)
);

// File: tb/rx_pkt_fifo_tb.sv
module rx_pkt_fifo_tb;
  logic clk = 0, rst_n = 0;
  logic [31:0] s_tdata = '0;
  logic s_tvalid = 0, s_tlast = 0, s_tready;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, failures = 0;
  logic [31:0] v;

  localparam logic [5:0] STAT = 6'h00, RST = 6'h18, OCC = 6'h1C, DATA = 6'h20, LEN = 6'h24;

  always #4 clk = ~clk;

  rx_pkt_fifo #(.AW(4), .LW(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic send_pkt(input int n, input logic [31:0] base, input bit with_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_tdata = base + 32'(i); s_tlast = with_last && (i == n - 1); s_tvalid = 1;
      while (!s_tready) @(negedge clk);
    end
    @(negedge clk); s_tvalid = 0; s_tlast = 0;
  endtask

  task automatic clean();
    wr(RST, 32'hA5);
    wr(STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 occupancy", OCC, 0);
    rd_chk("R1 length", LEN, 0);
    rd_chk("R1 status", STAT, 0);
    chk("R1 tready", 32'(s_tready), 1);
  endtask

  task automatic t_store_forward();
    send_pkt(2, 32'h100, 0);
    rd_chk("R2 partial packet hidden", OCC, 0);
    rd_chk("R5 no complete yet", STAT, 0);
    send_pkt(1, 32'h102, 1);
    rd_chk("R2 occupancy after tlast", OCC, 3);
    rd_chk("R5 complete bit", STAT, 32'h0400_0000);
    rd_chk("R3 length bytes", LEN, 12);
    rd_chk("R4 word0", DATA, 32'h100);
    rd_chk("R4 occupancy step", OCC, 2);
    rd_chk("R4 word1", DATA, 32'h101);
    rd_chk("R4 word2", DATA, 32'h102);
    rd_chk("R4 occupancy empty", OCC, 0);
    wr(STAT, 32'h0400_0000);
    rd_chk("R10 clear complete", STAT, 0);
  endtask

  task automatic t_order();
    clean();
    send_pkt(1, 32'h200, 1);
    send_pkt(2, 32'h300, 1);
    rd_chk("R3 first length", LEN, 4);
    rd_chk("R3 first data", DATA, 32'h200);
    rd_chk("R3 second length", LEN, 8);
    rd_chk("R3 second data0", DATA, 32'h300);
    rd_chk("R3 second data1", DATA, 32'h301);
  endtask

  task automatic t_underrun();
    clean();
    rd_chk("R6 data when empty", DATA, 0);
    rd_chk("R6 underrun bit", STAT, 32'h2000_0000);
  endtask

  task automatic t_overread();
    clean();
    send_pkt(1, 32'h400, 1);
    send_pkt(2, 32'h500, 1);
    wr(STAT, 32'hFFFF_FFFF);
    rd_chk("R7 length", LEN, 4);
    rd_chk("R7 data", DATA, 32'h400);
    rd_chk("R7 over-read value", DATA, 0);
    rd_chk("R7 over-read bit", STAT, 32'h4000_0000);
    rd_chk("R7 no word removed", OCC, 2);
    rd_chk("R7 next length", LEN, 8);
    rd_chk("R7 next data intact", DATA, 32'h500);
  endtask

  task automatic t_underread();
    clean();
    send_pkt(3, 32'h600, 1);
    send_pkt(1, 32'h700, 1);
    wr(STAT, 32'hFFFF_FFFF);
    rd_chk("R8 length", LEN, 12);
    rd_chk("R8 data", DATA, 32'h600);
    rd_chk("R8 next length", LEN, 4);
    rd_chk("R8 under-read bit", STAT, 32'h8000_0000);
    rd_chk("R8 leftover discarded", OCC, 1);
    rd_chk("R8 next packet data", DATA, 32'h700);
  endtask

  task automatic t_key();
    clean();
    send_pkt(2, 32'h800, 1);
    wr(RST, 32'h5A);
    rd_chk("R9 wrong key ignored occupancy", OCC, 2);
    rd_chk("R9 wrong key no reset bit", STAT, 32'h0400_0000);
    wr(RST, 32'hA5);
    rd_chk("R9 emptied", OCC, 0);
    rd_chk("R9 length queue emptied", LEN, 0);
    rd_chk("R9 reset done bit", STAT, 32'h0480_0000);
    send_pkt(1, 32'h900, 1);
    rd_chk("R9 length after reset", LEN, 4);
    rd_chk("R9 data after reset", DATA, 32'h900);
    wr(STAT, 32'h0080_0000);
    rd_chk("R10 selective clear", STAT, 32'h0400_0000);
  endtask

  task automatic t_lq_full();
    clean();
    for (int i = 0; i < 4; i++) send_pkt(1, 32'hA0 + 32'(i), 1);
    @(negedge clk);
    chk("R11 tready low on full length queue", 32'(s_tready), 0);
    fork
      send_pkt(1, 32'hA4, 1);
      begin
        repeat (3) @(negedge clk);
        rd_chk("R11 stalled packet not stored", OCC, 4);
        rd_chk("R11 length frees slot", LEN, 4);
      end
    join
    rd_chk("R11 stalled packet later stored", OCC, 5);
    rd_chk("R11 first word intact", DATA, 32'hA0);
  endtask

  task automatic t_full();
    clean();
    send_pkt(12, 32'hB00, 1);
    fork
      send_pkt(5, 32'hC00, 1);
      begin
        repeat (10) @(negedge clk);
        chk("R11 tready low on full storage", 32'(s_tready), 0);
        rd_chk("R12 tlast not stored yet", OCC, 12);
        rd_chk("R12 head length", LEN, 48);
        rd_chk("R12 head data", DATA, 32'hB00);
      end
    join
    rd_chk("R12 committed after tlast stored", OCC, 16);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_store_forward();
    t_order();
    t_underrun();
    t_overread();
    t_underread();
    t_key();
    t_lq_full();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule